// File: doc/BRIEF.md
# Serial Bit-Forcing Pass-Through

This block sits in series on a single-wire synchronous serial data line, between an upstream chip that drives the line and a downstream CPU that reads it. Each bit is sampled on the rising clock edge and re-driven on the following falling edge, so the outgoing line follows the incoming line one clock later and changes on the same edge polarity as the upstream source.

After reset the block waits for the first sampled logic 1, which it treats as a start bit. It then counts rising edges and, on the bit that lies a fixed offset after the start bit (32 by default), drives a 1 whatever value arrived. From then on it is a plain delay line until the next reset. Later start bits change nothing. A `done_o` flag reports that the single forced bit has been taken.

The line carries one bit on every clock and has no valid/ready handshake. The block cannot stall the upstream source, and the downstream reader cannot push back on it. The line's only flow control is the clock.

Top module: `serial_bit_forcer`

## Requirements
- R1: `ser_in_i` is sampled only on the rising edge of `clk_i`. Changes between rising edges do not affect the output.
- R2: `ser_out_o` changes only on falling edges of `clk_i`. It holds its value across a rising edge.
- R3: Except for the forced bit, the value driven after the falling edge that follows rising edge k equals `ser_in_i` sampled at rising edge k.
- R4: The start bit is the first rising-edge sample equal to 1 after reset, and it counts as bit 0. While no start bit has been seen, nothing is forced and `done_o` stays 0.
- R5: The bit sampled FORCE_AT rising edges after the start bit (default 32) is driven as 1, whether it arrived as 0 or as 1.
- R6: `done_o` rises on the rising edge that samples the forced bit and stays at 1 until reset.
- R7: After `done_o` is set, every further bit passes unchanged, including bits that look like start bits. No second bit is ever forced before reset.
- R8: While `arst_i` is high, `ser_out_o` and `done_o` are 0 and a 1 on `ser_in_i` does not arm the block. After reset, the next start bit restarts the count from zero, and a count left unfinished by the reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| arst_i | input | 1 | Asynchronous reset, active high |
| ser_in_i | input | 1 | Incoming serial data from the upstream source |
| ser_out_o | output | 1 | Outgoing serial data, one cycle late, launched on falling edges |
| done_o | output | 1 | High once the single forced bit has been taken |

## Verification
The line is driven with a stream whose start bit comes first, with streams whose start bit comes after 3, 11 or 17 zeros, and with a stream of zeros only. These separate the correct offset from an off-by-one in where counting begins, and show that zeros alone never arm the block. The bit at the forced offset is sent once as 0, where forcing is visible, and once as 1, where only `done_o` shows that forcing happened. After the force, runs of ones and alternating bits confirm that later start bits are ignored. A reset in the middle of a count, held while the input is 1, shows that the count is discarded and that forcing occurs at the new offset. Each bit is checked after both edges, and the input is toggled after each capture, so that sampling and launch on the wrong edge are both caught.

// File: rtl/sbf_pkg.sv
`timescale 1ns/1ps
package sbf_pkg;
  // Default distance, in bits, from the start bit to the forced bit
  localparam int unsigned FORCE_AT_DEF = 32;

  // Counter width able to hold the value FORCE_AT
  function automatic int unsigned cnt_width(input int unsigned force_at);
    return $clog2(force_at + 1);
  endfunction
endpackage

// File: rtl/sbf_capture.sv
`timescale 1ns/1ps
// Rising-edge capture register; the force request is OR-ed into the sampled bit
module sbf_capture (
  input  logic clk_i,
  input  logic arst_i,
  input  logic din_i,
  input  logic force_i,
  output logic q_o
);
  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) q_o <= 1'b0;
    else        q_o <= din_i | force_i;
  end
endmodule

// File: rtl/sbf_sequencer.sv
`timescale 1ns/1ps
// Start detect, bit counter and done state
module sbf_sequencer #(
  parameter int unsigned FORCE_AT = sbf_pkg::FORCE_AT_DEF,
  localparam int unsigned CNT_W   = sbf_pkg::cnt_width(FORCE_AT)
) (
  input  logic             clk_i,
  input  logic             arst_i,
  input  logic             din_i,
  output logic             hit_o,
  output logic             armed_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST_BEFORE = CNT_W'(FORCE_AT - 1);

  logic counting;
  assign counting = armed_o & ~done_o;
  assign hit_o    = counting & (cnt_o == LAST_BEFORE);

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      armed_o <= 1'b0;
      done_o  <= 1'b0;
      cnt_o   <= '0;
    end else begin
      if (!armed_o && din_i) armed_o <= 1'b1;
      if (counting)          cnt_o   <= cnt_o + 1'b1;
      if (hit_o)             done_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/sbf_launch.sv
`timescale 1ns/1ps
// Falling-edge launch register driving the outgoing line
module sbf_launch (
  input  logic clk_i,
  input  logic arst_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(negedge clk_i or posedge arst_i) begin
    if (arst_i) q_o <= 1'b0;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/serial_bit_forcer.sv
`timescale 1ns/1ps
module serial_bit_forcer #(
  parameter int unsigned FORCE_AT = sbf_pkg::FORCE_AT_DEF,
  localparam int unsigned CNT_W   = sbf_pkg::cnt_width(FORCE_AT)
) (
  input  logic clk_i,
  input  logic arst_i,
  input  logic ser_in_i,
  output logic ser_out_o,
  output logic done_o
);
  logic             hit;
  logic             armed_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cap_q;

  sbf_sequencer #(.FORCE_AT(FORCE_AT)) u_seq (
    .clk_i   (clk_i),
    .arst_i  (arst_i),
    .din_i   (ser_in_i),
    .hit_o   (hit),
    .armed_o (armed_q),
    .done_o  (done_q),
    .cnt_o   (cnt_q)
  );

  sbf_capture u_cap (
    .clk_i   (clk_i),
    .arst_i  (arst_i),
    .din_i   (ser_in_i),
    .force_i (hit),
    .q_o     (cap_q)
  );

  sbf_launch u_lau (
    .clk_i  (clk_i),
    .arst_i (arst_i),
    .d_i    (cap_q),
    .q_o    (ser_out_o)
  );

  assign done_o = done_q;
endmodule

// File: rtl/sbf_checker.sv
`timescale 1ns/1ps
module sbf_checker #(
  parameter int unsigned FORCE_AT = sbf_pkg::FORCE_AT_DEF,
  localparam int unsigned CNT_W   = sbf_pkg::cnt_width(FORCE_AT)
) (
  input logic             clk_i,
  input logic             arst_i,
  input logic             ser_in_i,
  input logic             ser_out_o,
  input logic             done_o,
  input logic             armed_q,
  input logic [CNT_W-1:0] cnt_q
);
  logic pv;
  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) pv <= 1'b0;
    else        pv <= 1'b1;
  end

  // R3
  pass_thru_chk: assert property (@(posedge clk_i) disable iff (arst_i)
    (pv && !$rose(done_o)) |-> (ser_out_o == $past(ser_in_i)));

  // R5
  forced_one_chk: assert property (@(posedge clk_i) disable iff (arst_i)
    (pv && $rose(done_o)) |-> ser_out_o);

  // R6
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (arst_i)
    done_o |=> done_o);

  // R5
  done_at_offset_chk: assert property (@(posedge clk_i) disable iff (arst_i)
    (pv && $rose(done_o)) |-> ($past(cnt_q) == CNT_W'(FORCE_AT - 1)));

  // R4
  idle_count_chk: assert property (@(posedge clk_i) disable iff (arst_i)
    !armed_q |-> (cnt_q == '0 && !done_o));

  // R7
  count_hold_chk: assert property (@(posedge clk_i) disable iff (arst_i)
    done_o |-> (cnt_q == CNT_W'(FORCE_AT)));

  // R8
  always @(negedge clk_i) begin
    if (arst_i) begin
      reset_quiet_chk: assert (!ser_out_o && !done_o);
    end
  end
endmodule

bind serial_bit_forcer sbf_checker #(.FORCE_AT(FORCE_AT)) u_sbf_chk (
  .clk_i     (clk_i),
  .arst_i    (arst_i),
  .ser_in_i  (ser_in_i),
  .ser_out_o (ser_out_o),
  .done_o    (done_o),
  .armed_q   (armed_q),
  .cnt_q     (cnt_q)
);

// File: tb/test_serial_bit_forcer.sv
`timescale 1ns/1ps
module test_serial_bit_forcer;
  localparam int FORCE_AT = 32;

  logic clk = 1'b0;
  logic arst = 1'b1;
  logic din = 1'b0;
  logic dout;
  logic done;

  always #4 clk = ~clk;  // 125 MHz

  serial_bit_forcer #(.FORCE_AT(FORCE_AT)) i_serial_bit_forcer (
    .clk_i     (clk),
    .arst_i    (arst),
    .ser_in_i  (din),
    .ser_out_o (dout),
    .done_o    (done)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Reference model state, derived from the requirements
  bit   m_armed = 1'b0;
  bit   m_done = 1'b0;
  int   m_idx = 0;
  int   forced_cnt = 0;
  logic exp_out = 1'b0;
  bit   exp_forced = 1'b0;

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // One bit period: check the previous bit, drive a new one, check after capture
  task automatic step(logic b);
    logic nxt;
    bit   f;
    @(negedge clk); #1;
    if (exp_forced) chk("R5 forced bit", dout, exp_out);
    else            chk("R1 R3 delayed bit", dout, exp_out);
    din = b;
    f = 1'b0;
    if (!m_armed) begin
      if (b) begin m_armed = 1'b1; m_idx = 0; end
      nxt = b;
    end else if (!m_done) begin
      m_idx++;
      if (m_idx == FORCE_AT) begin
        nxt = 1'b1; m_done = 1'b1; f = 1'b1; forced_cnt++;
      end else nxt = b;
    end else nxt = b;
    @(posedge clk); #1;
    chk("R2 held over rising edge", dout, exp_out);
    chk("R6 done flag", done, m_done);
    exp_out = nxt;
    exp_forced = f;
    din = ~b;  // upset after capture; must not reach the output (R1)
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    arst = 1'b1;
    din = 1'b1;
    m_armed = 1'b0; m_done = 1'b0; m_idx = 0; forced_cnt = 0;
    exp_out = 1'b0; exp_forced = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 out low in reset", dout, 1'b0);
    chk("R8 done low in reset", done, 1'b0);
    din = 1'b0;
    #1 arst = 1'b0;
  endtask

  // kind: 0 random, 1 alternating, 2 all ones
  function automatic logic pick(int kind, int j);
    case (kind)
      0: return logic'($urandom_range(0, 1));
      1: return logic'(j[0]);
      default: return 1'b1;
    endcase
  endfunction

  task automatic stream(int lead, int post, logic v_force, int kind);
    for (int i = 0; i < lead; i++) step(1'b0);
    step(1'b1);
    for (int j = 1; j <= post; j++) step((j == FORCE_AT) ? v_force : pick(kind, j));
  endtask

  task automatic t_reset_state();
    do_reset();
    step(1'b0);
    chk("R8 out after reset", dout, 1'b0);
  endtask

  task automatic t_start_first();
    do_reset();
    stream(0, 45, 1'b0, 0);
    step(1'b0);
    chk_int("R5 one forced bit", forced_cnt, 1);
    chk("R6 done high", done, 1'b1);
  endtask

  task automatic t_late_start();
    do_reset();
    stream(11, 50, 1'b0, 1);
    step(1'b0);
    chk_int("R4 R5 late start forced once", forced_cnt, 1);
  endtask

  task automatic t_already_one();
    do_reset();
    stream(3, 40, 1'b1, 0);
    step(1'b0);
    chk_int("R5 forced when already 1", forced_cnt, 1);
    chk("R6 done with 1 at offset", done, 1'b1);
  endtask

  task automatic t_later_starts();
    do_reset();
    stream(17, 34, 1'b0, 0);
    for (int k = 0; k < 40; k++) step(1'b1);
    for (int k = 0; k < 70; k++) step(logic'(k[0]));
    for (int k = 0; k < 70; k++) step(logic'($urandom_range(0, 1)));
    step(1'b0);
    chk_int("R7 no second force", forced_cnt, 1);
    chk("R7 done still high", done, 1'b1);
  endtask

  task automatic t_reset_mid_count();
    do_reset();
    stream(2, 20, 1'b0, 0);
    do_reset();
    step(1'b0);
    chk("R8 done cleared", done, 1'b0);
    stream(5, 40, 1'b0, 1);
    step(1'b0);
    chk_int("R8 count restarted", forced_cnt, 1);
  endtask

  task automatic t_no_start();
    do_reset();
    for (int k = 0; k < 50; k++) step(1'b0);
    step(1'b0);
    chk("R4 no start no done", done, 1'b0);
    chk("R4 output stays low", dout, 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_start_first();
    t_late_start();
    t_already_one();
    t_later_starts();
    t_reset_mid_count();
    t_no_start();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule